// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block turns a single asynchronous serial input into parallel bytes. The line rests high. Each frame has one low start bit, then eight data bits with the least significant bit first, then one high stop bit. Every bit lasts one bit period. A runtime divisor input sets that period in system-clock cycles, so one build can serve many baud rates from a single clock.

The receiver passes the line through a synchroniser and waits for a high-to-low transition while it is idle. It checks the start bit half a bit later and then samples each data bit at its centre, stepping one bit period at a time. It samples the stop bit the same way. A finished frame appears on the byte output together with a one-cycle valid strobe. A framing-error flag accompanies the strobe when the stop bit was low.

The result stream has no back-pressure. The consumer must take the byte in the strobe cycle. The byte and flag then stay unchanged until the next frame completes, so a slower consumer has about one frame time to read them.

Top module: `serial_frame_rx`

## Requirements
- R1: While the active-low asynchronous reset is asserted, `rx_byte` reads 0x00 and `rx_valid`, `frame_err` and `rx_busy` read 0.
- R2: A frame on `rx_line` (low start bit, 8 data bits with bit 0 sent first, high stop bit, each `bit_div`+1 clock cycles long, `bit_div` at least 1) is delivered as the same byte on `rx_byte`.
- R3: A falling edge on `rx_line` seen while idle starts reception. `rx_busy` is high from shortly after that edge until the stop bit is sampled, and is low in the cycle `rx_valid` is high.
- R4: `rx_valid` is high for exactly one clock cycle per received frame. `rx_byte` changes only in that cycle and holds its value afterwards.
- R5: A low stop bit sets `frame_err` in the cycle of `rx_valid`, and the byte is still delivered. A high stop bit gives `frame_err` = 0. `frame_err` clears when the next frame starts.
- R6: A low pulse shorter than half a bit period is treated as a glitch. It produces no `rx_valid` and leaves the receiver idle.
- R7: Data bits of value zero are never taken as start bits: 0x00 and 0xFF each decode correctly.
- R8: The receiver is ready for the next start edge in the cycle it issues `rx_valid`, so frames sent with no idle time between a stop bit and the next start bit are all received.
- R9: Changing `bit_div` between frames changes the bit period at run time. Frames at several divisors decode correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| bit_div | input | 16 | Clock cycles per bit, minus one |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is updated |
| frame_err | output | 1 | Stop bit of the last frame was low |
| rx_busy | output | 1 | Frame reception in progress |

## Verification
The bound checker watches the output rules that hold in every cycle:
- the strobe never lasts more than one cycle;
- the busy flag is low when the strobe fires;
- the error flag never rises without the strobe;
- the error flag is clear whenever busy rises;
- the byte output never changes outside a strobe cycle.

Only the bench's scenarios can show that the bits are recovered at the right sample points. These scenarios cover several divisors, the all-zero and all-one bytes, back-to-back frames, a low stop bit and a short glitch. A scoreboard compares each delivered byte and error flag with the frame that was driven.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
// Multi-stage synchroniser for the raw line plus falling-edge detect.
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fell
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign dout = chain[STAGES-1];
  assign fell = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
// Loadable down-counter; tick is high while the count sits at zero.
module rx_bit_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/rx_frame_fsm.sv
// Frame sequencer: start check, data shift (bit 0 first), stop check.
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int W         = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line,
  input  logic                 fell,
  input  logic                 tick,
  input  logic [W-1:0]         full_val,
  input  logic [W-1:0]         half_val,
  output logic                 load,
  output logic [W-1:0]         load_val,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 valid,
  output logic                 err,
  output logic                 busy
);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [IW-1:0] LAST = IW'(DATA_BITS - 1);

  rx_state_e            state;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;

  always_comb begin
    load     = (state == RX_IDLE) ? fell : tick;
    load_val = (state == RX_IDLE) ? half_val : full_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      idx      <= '0;
      shreg    <= '0;
      data_out <= '0;
      valid    <= 1'b0;
      err      <= 1'b0;
    end else begin
      valid <= 1'b0;
      unique case (state)
        RX_IDLE: if (fell) begin
          state <= RX_START;
          err   <= 1'b0;
        end
        RX_START: if (tick) begin
          if (line) state <= RX_IDLE;
          else begin
            state <= RX_DATA;
            idx   <= '0;
          end
        end
        RX_DATA: if (tick) begin
          shreg <= {line, shreg[DATA_BITS-1:1]};
          idx   <= idx + 1'b1;
          if (idx == LAST) state <= RX_STOP;
        end
        RX_STOP: if (tick) begin
          data_out <= shreg;
          valid    <= 1'b1;
          err      <= ~line;
          state    <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign busy = (state != RX_IDLE);
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int DATA_BITS   = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  input  logic [DIV_W-1:0]     bit_div,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 frame_err,
  output logic                 rx_busy
);
  logic             line_s, line_fell, tick, load;
  logic [DIV_W-1:0] load_val, half_m1;
  logic [DIV_W:0]   period;

  // half period = (div+1)/2 rounded down; timer loads one less
  assign period  = {1'b0, bit_div} + 1'b1;
  assign half_m1 = period[DIV_W:1] - 1'b1;

  rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s), .fell(line_fell)
  );

  rx_bit_timer #(.W(DIV_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .tick(tick)
  );

  rx_frame_fsm #(.DATA_BITS(DATA_BITS), .W(DIV_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .line(line_s), .fell(line_fell), .tick(tick),
    .full_val(bit_div), .half_val(half_m1), .load(load), .load_val(load_val),
    .data_out(rx_byte), .valid(rx_valid), .err(frame_err), .busy(rx_busy)
  );
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 rx_valid,
  input logic                 frame_err,
  input logic                 rx_busy
);
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_byte_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> rx_valid);

  p_idle_at_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rx_busy);

  p_err_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> rx_valid);

  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> !frame_err);
endmodule

bind serial_frame_rx serial_frame_rx_chk #(.DATA_BITS(DATA_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
  .frame_err(frame_err), .rx_busy(rx_busy)
);

// File: tb/test_serial_frame_rx.sv
module test_serial_frame_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_line;
  logic [15:0] bit_div;
  logic [7:0]  rx_byte;
  logic        rx_valid, frame_err, rx_busy;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];
  logic       prev_valid = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  serial_frame_rx i_serial_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_div(bit_div),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .frame_err(frame_err),
    .rx_busy(rx_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic hold_bit(input logic v);
    rx_line = v;
    repeat (int'(bit_div) + 1) @(negedge clk);
  endtask

  // driver: push expectation, then drive one frame
  task automatic send_frame(input logic [7:0] b, input logic stop_v);
    exp_q.push_back({~stop_v, b});
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(b[i]);
    hold_bit(stop_v);
  endtask

  task automatic idle_bits(input int n);
    rx_line = 1'b1;
    repeat (n * (int'(bit_div) + 1)) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rx_valid && prev_valid)
        chk(1'b0, "R4 valid longer than one cycle", 2, 1);
      if (rx_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected valid", 1, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(rx_byte === e[7:0], "R2 byte", rx_byte, e[7:0]);
          chk(frame_err === e[8], "R5 frame_err", frame_err, e[8]);
          chk(rx_busy === 1'b0, "R3 busy low at valid", rx_busy, 0);
        end
      end
      prev_valid = rx_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; bit_div = 16'd15;
    repeat (4) @(negedge clk);
    chk(rx_byte === 8'h00, "R1 byte at reset", rx_byte, 0);
    chk(rx_valid === 1'b0, "R1 valid at reset", rx_valid, 0);
    chk(frame_err === 1'b0, "R1 err at reset", frame_err, 0);
    chk(rx_busy === 1'b0, "R1 busy at reset", rx_busy, 0);
    rst_n = 1'b1;
    idle_bits(2);

    // R2 basic patterns, R3 busy during frame
    fork
      send_frame(8'h55, 1'b1);
      begin
        repeat (6) @(negedge clk);
        chk(rx_busy === 1'b1, "R3 busy after start", rx_busy, 1);
      end
    join
    idle_bits(1);
    send_frame(8'hA5, 1'b1);
    idle_bits(1);

    // R7 all zeros / all ones
    send_frame(8'h00, 1'b1);
    idle_bits(1);
    send_frame(8'hFF, 1'b1);
    idle_bits(3);
    chk(rx_byte === 8'hFF, "R4 byte held", rx_byte, 8'hFF);
    chk(rx_busy === 1'b0, "R7 idle after 0xFF", rx_busy, 0);

    // R5 low stop bit, then cleared at next frame start
    send_frame(8'h5A, 1'b0);
    idle_bits(2);
    chk(frame_err === 1'b1, "R5 err held", frame_err, 1);
    fork
      send_frame(8'h3C, 1'b1);
      begin
        repeat (8) @(negedge clk);
        chk(frame_err === 1'b0, "R5 err cleared at start", frame_err, 0);
      end
    join
    idle_bits(1);

    // R6 short glitch: 3 cycles low, half bit is 8 cycles
    rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    idle_bits(2);
    chk(rx_busy === 1'b0, "R6 idle after glitch", rx_busy, 0);
    chk(rx_byte === 8'h3C, "R6 byte unchanged", rx_byte, 8'h3C);

    // R8 back-to-back frames
    send_frame(8'h81, 1'b1);
    send_frame(8'h7E, 1'b1);
    send_frame(8'h00, 1'b1);
    idle_bits(2);

    // R9 other divisors
    bit_div = 16'd3;
    idle_bits(2);
    send_frame(8'hC3, 1'b1);
    send_frame(8'h12, 1'b1);
    idle_bits(2);
    bit_div = 16'd24;
    idle_bits(2);
    send_frame(8'h96, 1'b1);
    idle_bits(2);

    chk(exp_q.size() == 0, "R9 all frames delivered", exp_q.size(), 0);
    summary();
  end
endmodule